// File: doc/BRIEF.md
# Byte-Sliced Bidirectional Latching Transceiver

This block connects two 16-bit ports, called A and B, through two storage latches, one for each direction of flow. Data is never inverted. Each port is cut into two bytes, and every byte has its own control set for each direction. A control set has three active-low inputs: a direction enable, a latch enable and an output enable. The two halves can be run apart, or their controls can be tied together to move a full 16-bit word.

The block is purely level-sensitive and has no clock. Each byte of each latch has an effective gate, formed as the OR of its direction enable and its latch enable. While that gate is low, the byte follows the source port. When either control rises, the byte captures the value it had just before. The output enable only decides whether the latched byte is driven onto the far port. It never stops data from entering the latch.

The tri-state pins are split into three signals: an input vector, an output vector and a drive-enable per byte. An output byte that is not driven reads as zero. The latch contents are undefined after power-up until they are first loaded.

Top module: `bltx_xcvr`

## Requirements
- R1: While `eab_n[k]`, `leab_n[k]` and `oeab_n[k]` are all 0, byte k of `b_out` equals byte k of `a_in`. Byte k covers bits 8k+7..8k. `b_oe[k]` is 1.
- R2: A rise of `leab_n[k]` while `eab_n[k]` is 0 captures byte k of `a_in`. After that, changes on `a_in` do not reach `b_out` byte k.
- R3: A rise of `eab_n[k]` also captures byte k. While `eab_n[k]` is 1, toggling `leab_n[k]` or changing `a_in` leaves the stored byte unchanged. This is seen once B drive is enabled again.
- R4: `b_oe[k]` is 1 exactly when `eab_n[k]` and `oeab_n[k]` are both 0. When `b_oe[k]` is 0, byte k of `b_out` reads zero.
- R5: The A-to-B latch loads even while `oeab_n[k]` is 1. Data captured with the outputs disabled appears on `b_out` when `oeab_n[k]` falls.
- R6: The B-to-A direction follows R1 to R5 in the same way. It uses `eba_n`, `leba_n` and `oeba_n`, the source `b_in`, and the outputs `a_out` and `a_oe`.
- R7: The controls of byte k act only on byte k. Byte 0 can hold while byte 1 stays transparent.
- R8: Both directions may be enabled on one byte at once without a combinational loop. `b_out` then reflects the A source and `a_out` reflects the B source, both non-inverted, for arbitrary data and control sequences.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 16 | A port input value |
| a_out | output | 16 | A port driven value (B-to-A latch) |
| a_oe | output | 2 | Per-byte drive enable for the A port |
| b_in | input | 16 | B port input value |
| b_out | output | 16 | B port driven value (A-to-B latch) |
| b_oe | output | 2 | Per-byte drive enable for the B port |
| eab_n | input | 2 | Per-byte A-to-B direction enable, active low |
| leab_n | input | 2 | Per-byte A-to-B latch enable, active low |
| oeab_n | input | 2 | Per-byte A-to-B output enable, active low |
| eba_n | input | 2 | Per-byte B-to-A direction enable, active low |
| leba_n | input | 2 | Per-byte B-to-A latch enable, active low |
| oeba_n | input | 2 | Per-byte B-to-A output enable, active low |

## Verification
Transparent passes with changing data show that the latch passes data through. Later data changes after a latch-enable rise, and separately after an enable rise, tell the two capture paths apart. Loading with the output enable high, then enabling the outputs, separates latch gating from drive gating. Split-byte control patterns and simultaneous two-way enables, followed by a long random control and data sequence, tell byte independence and loop-free two-way operation apart from a design that shares controls or feeds outputs back.

// File: rtl/bltx_pkg.sv
// Package: shared defaults and helpers for the byte-sliced transceiver.
// Assumes byte slices are packed little-endian: byte k is bits 8k+7..8k.
package bltx_pkg;
    localparam int unsigned DEF_BYTE_W  = 8;
    localparam int unsigned DEF_N_BYTES = 2;

    // Per-byte decoded control for one direction.
    typedef struct packed {
        logic hold;   // 1 = latch byte keeps its value
        logic drive;  // 1 = far port byte is driven
    } lane_ctl_t;
endpackage

// File: rtl/bltx_ctrl.sv
// Module: decodes the three active-low controls of one direction into
// a per-byte latch hold signal and a per-byte drive enable.
// Assumes all controls are level signals; no clock is present.
module bltx_ctrl #(
    parameter int unsigned N_BYTES = 2
) (
    input  logic [N_BYTES-1:0] en_n,
    input  logic [N_BYTES-1:0] le_n,
    input  logic [N_BYTES-1:0] oe_n,
    output bltx_pkg::lane_ctl_t ctl [N_BYTES]
);
    for (genvar k = 0; k < N_BYTES; k++) begin : g_byte
        // Gate decode: hold while either enable is high; drive needs enable and output enable low.
        always_comb begin
            ctl[k].hold  = en_n[k] | le_n[k];
            ctl[k].drive = ~en_n[k] & ~oe_n[k];
        end
    end
endmodule

// File: rtl/bltx_store.sv
// Module: one byte-sliced level-sensitive storage latch per direction.
// Each byte is transparent while its hold is low and keeps its value
// while hold is high. Contents are undefined until first loaded.
module bltx_store #(
    parameter int unsigned BYTE_W  = 8,
    parameter int unsigned N_BYTES = 2,
    localparam int unsigned W      = BYTE_W * N_BYTES
) (
    input  logic [W-1:0]        d,
    input  bltx_pkg::lane_ctl_t ctl [N_BYTES],
    output logic [W-1:0]        q
);
    logic [BYTE_W-1:0] q_mem [N_BYTES];

    for (genvar k = 0; k < N_BYTES; k++) begin : g_byte
        // Latch byte: follow source while the gate is open.
        always_latch begin
            if (!ctl[k].hold) q_mem[k] <= d[k*BYTE_W +: BYTE_W];
        end
        assign q[k*BYTE_W +: BYTE_W] = q_mem[k];
    end
endmodule

// File: rtl/bltx_drive.sv
// Module: per-byte output stage that stands in for a tri-state buffer.
// An undriven byte reads zero and its drive enable is low.
module bltx_drive #(
    parameter int unsigned BYTE_W  = 8,
    parameter int unsigned N_BYTES = 2,
    localparam int unsigned W      = BYTE_W * N_BYTES
) (
    input  logic [W-1:0]        q,
    input  bltx_pkg::lane_ctl_t ctl [N_BYTES],
    output logic [W-1:0]        dout,
    output logic [N_BYTES-1:0]  oe
);
    for (genvar k = 0; k < N_BYTES; k++) begin : g_byte
        // Output gate: pass latched byte only when driving.
        always_comb begin
            oe[k] = ctl[k].drive;
            dout[k*BYTE_W +: BYTE_W] = ctl[k].drive ? q[k*BYTE_W +: BYTE_W] : '0;
        end
    end
endmodule

// File: rtl/bltx_lane.sv
// Module: one direction of flow: decode, latch and output stage.
// Assumes the source and the destination are separate vectors, so no
// loop can form through the other direction.
module bltx_lane #(
    parameter int unsigned BYTE_W  = 8,
    parameter int unsigned N_BYTES = 2,
    localparam int unsigned W      = BYTE_W * N_BYTES
) (
    input  logic [W-1:0]       src,
    input  logic [N_BYTES-1:0] en_n,
    input  logic [N_BYTES-1:0] le_n,
    input  logic [N_BYTES-1:0] oe_n,
    output logic [W-1:0]       dst,
    output logic [N_BYTES-1:0] dst_oe
);
    bltx_pkg::lane_ctl_t ctl [N_BYTES];
    logic [W-1:0]        q;

    bltx_ctrl #(.N_BYTES(N_BYTES)) u_ctrl (
        .en_n(en_n), .le_n(le_n), .oe_n(oe_n), .ctl(ctl)
    );
    bltx_store #(.BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) u_store (
        .d(src), .ctl(ctl), .q(q)
    );
    bltx_drive #(.BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) u_drive (
        .q(q), .ctl(ctl), .dout(dst), .oe(dst_oe)
    );
endmodule

// File: rtl/bltx_xcvr.sv
// Module: top of the byte-sliced bidirectional latching transceiver.
// Two independent lanes, A-to-B and B-to-A, each with per-byte controls.
// Assumes tri-state pins are split into input, output and drive enable.
module bltx_xcvr #(
    parameter int unsigned BYTE_W  = bltx_pkg::DEF_BYTE_W,
    parameter int unsigned N_BYTES = bltx_pkg::DEF_N_BYTES,
    localparam int unsigned W      = BYTE_W * N_BYTES
) (
    input  logic [W-1:0]       a_in,
    output logic [W-1:0]       a_out,
    output logic [N_BYTES-1:0] a_oe,
    input  logic [W-1:0]       b_in,
    output logic [W-1:0]       b_out,
    output logic [N_BYTES-1:0] b_oe,
    input  logic [N_BYTES-1:0] eab_n,
    input  logic [N_BYTES-1:0] leab_n,
    input  logic [N_BYTES-1:0] oeab_n,
    input  logic [N_BYTES-1:0] eba_n,
    input  logic [N_BYTES-1:0] leba_n,
    input  logic [N_BYTES-1:0] oeba_n
);
    // A-to-B lane: stores a_in, drives the B port.
    bltx_lane #(.BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) u_ab (
        .src(a_in), .en_n(eab_n), .le_n(leab_n), .oe_n(oeab_n),
        .dst(b_out), .dst_oe(b_oe)
    );
    // B-to-A lane: stores b_in, drives the A port.
    bltx_lane #(.BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) u_ba (
        .src(b_in), .en_n(eba_n), .le_n(leba_n), .oe_n(oeba_n),
        .dst(a_out), .dst_oe(a_oe)
    );
endmodule

// File: rtl/bltx_checker.sv
// Module: assertion checker bound to the transceiver top. The block has
// no clock, so the checks are immediate assertions on settled levels.
module bltx_checker #(
    parameter int unsigned BYTE_W  = 8,
    parameter int unsigned N_BYTES = 2,
    localparam int unsigned W      = BYTE_W * N_BYTES
) (
    input logic [W-1:0]       a_in,
    input logic [W-1:0]       a_out,
    input logic [N_BYTES-1:0] a_oe,
    input logic [W-1:0]       b_in,
    input logic [W-1:0]       b_out,
    input logic [N_BYTES-1:0] b_oe,
    input logic [N_BYTES-1:0] eab_n,
    input logic [N_BYTES-1:0] leab_n,
    input logic [N_BYTES-1:0] oeab_n,
    input logic [N_BYTES-1:0] eba_n,
    input logic [N_BYTES-1:0] leba_n,
    input logic [N_BYTES-1:0] oeba_n
);
    for (genvar k = 0; k < N_BYTES; k++) begin : g_byte
        // A-to-B transparent path and idle level.
        always_comb begin
            if (!eab_n[k] && !leab_n[k] && !oeab_n[k])
                a_r1_ab_transparent: assert (b_out[k*BYTE_W +: BYTE_W] == a_in[k*BYTE_W +: BYTE_W])
                    else $error("R1 transparent A-to-B mismatch byte %0d", k);
            if (!b_oe[k])
                a_r4_b_idle_zero: assert (b_out[k*BYTE_W +: BYTE_W] == '0)
                    else $error("R4 undriven B byte %0d not zero", k);
        end
        // B-to-A transparent path and idle level.
        always_comb begin
            if (!eba_n[k] && !leba_n[k] && !oeba_n[k])
                a_r6_ba_transparent: assert (a_out[k*BYTE_W +: BYTE_W] == b_in[k*BYTE_W +: BYTE_W])
                    else $error("R6 transparent B-to-A mismatch byte %0d", k);
            if (!a_oe[k])
                a_r6_a_idle_zero: assert (a_out[k*BYTE_W +: BYTE_W] == '0)
                    else $error("R6 undriven A byte %0d not zero", k);
        end
    end
endmodule

bind bltx_xcvr bltx_checker #(.BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) u_chk (.*);

// File: tb/bltx_xcvr_tb.sv
// Bench: scoreboard. The driver task applies data, then controls, updates
// a reference model of both latches and queues the expected ports; a
// monitor at the falling clock edge pops and compares.
module bltx_xcvr_tb;
    localparam int W = 16;
    localparam int NB = 2;

    typedef struct packed {
        logic [W-1:0]  a_out;
        logic [NB-1:0] a_oe;
        logic [W-1:0]  b_out;
        logic [NB-1:0] b_oe;
    } exp_t;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz pacing clock

    logic [W-1:0]  a_in = '0, b_in = '0;
    logic [W-1:0]  a_out, b_out;
    logic [NB-1:0] a_oe, b_oe;
    logic [NB-1:0] eab_n = '1, leab_n = '1, oeab_n = '1;
    logic [NB-1:0] eba_n = '1, leba_n = '1, oeba_n = '1;

    bltx_xcvr u_dut (
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .eab_n(eab_n), .leab_n(leab_n), .oeab_n(oeab_n),
        .eba_n(eba_n), .leba_n(leba_n), .oeba_n(oeba_n)
    );

    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    exp_t exp_q[$];
    string tag_q[$];
    logic [W-1:0] m_ab = '0, m_ba = '0;

    // Reference latch update from current bench levels.
    task automatic model_update();
        for (int k = 0; k < NB; k++) begin
            if (!(eab_n[k] | leab_n[k])) m_ab[k*8 +: 8] = a_in[k*8 +: 8];
            if (!(eba_n[k] | leba_n[k])) m_ba[k*8 +: 8] = b_in[k*8 +: 8];
        end
    endtask

    task automatic step(input logic [W-1:0] ai, input logic [W-1:0] bi,
                        input logic [1:0] eab, input logic [1:0] leab, input logic [1:0] oeab,
                        input logic [1:0] eba, input logic [1:0] leba, input logic [1:0] oeba,
                        input string tag);
        exp_t e;
        @(posedge clk);
        a_in = ai; b_in = bi;
        model_update();
        #1;
        eab_n = eab; leab_n = leab; oeab_n = oeab;
        eba_n = eba; leba_n = leba; oeba_n = oeba;
        model_update();
        for (int k = 0; k < NB; k++) begin
            e.b_oe[k] = !eab_n[k] && !oeab_n[k];
            e.a_oe[k] = !eba_n[k] && !oeba_n[k];
            e.b_out[k*8 +: 8] = e.b_oe[k] ? m_ab[k*8 +: 8] : 8'h00;
            e.a_out[k*8 +: 8] = e.a_oe[k] ? m_ba[k*8 +: 8] : 8'h00;
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare settled outputs against queued expectations.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (b_out !== e.b_out || b_oe !== e.b_oe) begin
                errors++;
                $display("FAIL %s B side: got b_out=%h b_oe=%b expected b_out=%h b_oe=%b",
                         t, b_out, b_oe, e.b_out, e.b_oe);
            end
            checks++;
            if (a_out !== e.a_out || a_oe !== e.a_oe) begin
                errors++;
                $display("FAIL %s A side: got a_out=%h a_oe=%b expected a_out=%h a_oe=%b",
                         t, a_out, a_oe, e.a_out, e.a_oe);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements): got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        // Reset-like state: everything disabled (R4).
        step(16'h0000, 16'h0000, 2'b11, 2'b11, 2'b11, 2'b11, 2'b11, 2'b11, "R4 idle");
        // R1 transparent A-to-B, two data patterns.
        step(16'h1234, 16'h0000, 2'b00, 2'b00, 2'b00, 2'b11, 2'b11, 2'b11, "R1 pass");
        step(16'hABCD, 16'h0000, 2'b00, 2'b00, 2'b00, 2'b11, 2'b11, 2'b11, "R1 pass2");
        // R2 capture on latch enable rise, then data change is blocked.
        step(16'hABCD, 16'h0000, 2'b00, 2'b11, 2'b00, 2'b11, 2'b11, 2'b11, "R2 capture");
        step(16'h5555, 16'h0000, 2'b00, 2'b11, 2'b00, 2'b11, 2'b11, 2'b11, "R2 hold");
        // R3 capture on enable rise, LE toggles while enable high.
        step(16'h5555, 16'h0000, 2'b00, 2'b00, 2'b00, 2'b11, 2'b11, 2'b11, "R3 open");
        step(16'h5555, 16'h0000, 2'b11, 2'b00, 2'b00, 2'b11, 2'b11, 2'b11, "R3 E rise R4 off");
        step(16'h0F0F, 16'h0000, 2'b11, 2'b11, 2'b00, 2'b11, 2'b11, 2'b11, "R3 le toggle");
        step(16'hF0F0, 16'h0000, 2'b11, 2'b00, 2'b00, 2'b11, 2'b11, 2'b11, "R3 le toggle2");
        step(16'hF0F0, 16'h0000, 2'b00, 2'b11, 2'b00, 2'b11, 2'b11, 2'b11, "R3 reenable");
        // R5 load with outputs disabled, then enable outputs.
        step(16'h7E7E, 16'h0000, 2'b00, 2'b00, 2'b11, 2'b11, 2'b11, 2'b11, "R5 load hidden");
        step(16'h7E7E, 16'h0000, 2'b00, 2'b11, 2'b11, 2'b11, 2'b11, 2'b11, "R5 capture hidden");
        step(16'h0000, 16'h0000, 2'b00, 2'b11, 2'b00, 2'b11, 2'b11, 2'b11, "R5 show");
        // R6 B-to-A: pass, capture, enable hold, hidden load.
        step(16'h0000, 16'hC3A5, 2'b11, 2'b11, 2'b11, 2'b00, 2'b00, 2'b00, "R6 pass");
        step(16'h0000, 16'hC3A5, 2'b11, 2'b11, 2'b11, 2'b00, 2'b11, 2'b00, "R6 capture");
        step(16'h0000, 16'h9999, 2'b11, 2'b11, 2'b11, 2'b00, 2'b11, 2'b00, "R6 hold");
        step(16'h0000, 16'h9999, 2'b11, 2'b11, 2'b11, 2'b11, 2'b00, 2'b11, "R6 E high");
        step(16'h0000, 16'h2468, 2'b11, 2'b11, 2'b11, 2'b11, 2'b00, 2'b11, "R6 E high data");
        step(16'h0000, 16'h2468, 2'b11, 2'b11, 2'b11, 2'b00, 2'b11, 2'b00, "R6 reenable");
        step(16'h0000, 16'h3C3C, 2'b11, 2'b11, 2'b11, 2'b00, 2'b00, 2'b11, "R6 hidden load");
        step(16'h0000, 16'h3C3C, 2'b11, 2'b11, 2'b11, 2'b00, 2'b11, 2'b00, "R6 show");
        // R7 byte 0 holds, byte 1 transparent; output enables split.
        step(16'h1122, 16'h0000, 2'b00, 2'b00, 2'b00, 2'b11, 2'b11, 2'b11, "R7 load");
        step(16'h1122, 16'h0000, 2'b00, 2'b01, 2'b00, 2'b11, 2'b11, 2'b11, "R7 split");
        step(16'h88EE, 16'h0000, 2'b00, 2'b01, 2'b00, 2'b11, 2'b11, 2'b11, "R7 upper follows");
        step(16'h88EE, 16'h0000, 2'b00, 2'b01, 2'b10, 2'b11, 2'b11, 2'b11, "R7 oe split");
        // R8 both directions enabled together.
        step(16'h1111, 16'h2222, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, "R8 both");
        step(16'hDEAD, 16'hBEEF, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, "R8 both2");
        // R8 random control and data sequence.
        for (int i = 0; i < 400; i++) begin
            step(W'($urandom), W'($urandom),
                 2'($urandom), 2'($urandom), 2'($urandom),
                 2'($urandom), 2'($urandom), 2'($urandom), "R8 random");
        end
        @(posedge clk);
        @(posedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule